// File: doc/BRIEF.md
# Dual-Mode Timer Compare Unit

This block is the timing core of a time-triggered CAN controller. It keeps two counters that advance together on a tick enable: a reference counter and a cycle counter. It also holds three compare registers. On every tick the block checks each compare register against one of the counters. When they are equal, the block latches a sticky flag for that compare and drives a combined interrupt for the flags that software has enabled.

A mode input picks between event-trigger and time-trigger operation. In event-trigger mode all three compares watch the reference counter. When compare 0 matches and the clear-on-match input is set, the reference counter restarts at zero on that tick. In time-trigger mode compare 0 still watches the reference counter, but compares 1 and 2 watch the cycle counter, and the reference counter is never cleared by a match. Software reads and writes the counters, the compares and the flags through a simple register port.

Top module: `ttc_timer_cmp`

## Requirements
- R1: After a synchronous reset, both counters, all compare registers, all flags, the interrupt output and the read data are zero.
- R2: Each counter increments by one, wrapping from all-ones to zero, on every clock edge where `tick_en` is 1. It holds its value when `tick_en` is 0.
- R3: In event-trigger mode (`mode_tt`=0) with `clr_on_match`=1, a tick taken while the reference counter equals compare 0 loads the reference counter with 0. Counting then continues 1, 2 and so on.
- R4: With `clr_on_match`=0, or in time-trigger mode (`mode_tt`=1), a tick taken while the reference counter equals compare 0 advances the counter to n+1 as usual.
- R5: In event-trigger mode, compares 0, 1 and 2 are each checked against the reference counter.
- R6: In time-trigger mode, compare 0 is checked against the reference counter, and compares 1 and 2 are checked against the cycle counter.
- R7: A match is a tick taken while the watched counter equals the compare value. A match sets flag bit i (bit 0 for compare 0, bit 1 for compare 1, bit 2 for compare 2) at that clock edge, so the flag is visible one clock later. The flag stays set until it is cleared.
- R8: A write to address 5 clears each flag bit whose data bit is 1 and leaves the bits written 0 unchanged. A match in the same cycle as the clear leaves that flag set.
- R9: `irq` is a registered output. It equals the OR of `flags[i] & irq_en[i]` over all i, and it updates at the same edge as the flags.
- R10: Register map: address 0 is the reference counter, 1 the cycle counter, 2 to 4 compares 0 to 2, and 5 the flags (zero-extended). Other addresses read as 0. `rd_data` returns the value addressed by `rd_addr` one clock later. A write to a counter in a given cycle takes priority over that cycle's tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable; a match is only detected in a tick cycle |
| mode_tt | input | 1 | 0 = event-trigger mode, 1 = time-trigger mode |
| clr_on_match | input | 1 | In event-trigger mode, clear the reference counter on a compare 0 match |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data (at address 5, a 1 in a bit clears that flag) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Registered read data |
| irq_en | input | 3 | Per-compare interrupt enables |
| flags | output | 3 | Sticky compare-match flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker relies on a few properties of the inputs:
- Control inputs change only between clock edges.
- A write to a counter is an explicit override. For that reason, the counting properties exclude cycles with a write to the same counter.
- The flag-retention property excludes cycles that write the flag address.

The bench drives every input on the falling edge. It builds the design with 4-bit counters, so both counters wrap many times. It sweeps every compare 0 value in both modes, with clear-on-match both set and cleared. Across the sweep, the tick gaps, read addresses and interrupt enables are varied. Directed cases then cover a flag clear in the same cycle as a match, a clear written with zeros, and a counter write during a tick.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_CMP = 3;

  localparam logic [ADDR_W-1:0] A_REF      = 3'd0;
  localparam logic [ADDR_W-1:0] A_CYC      = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP_BASE = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG     = 3'd5;

  function automatic logic [ADDR_W-1:0] cmp_addr(input int idx);
    return A_CMP_BASE + ADDR_W'(idx);
  endfunction
endpackage

// File: rtl/ttc_counter.sv
module ttc_counter #(
  parameter int W         = 16,
  parameter bit CLEARABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  logic clr_eff;

  generate
    if (CLEARABLE) begin : g_clr
      assign clr_eff = clear;
    end else begin : g_noclr
      assign clr_eff = 1'b0 & clear;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      if (clr_eff) cnt <= '0;
      else         cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ttc_cmp_bank.sv
module ttc_cmp_bank #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   wr_sel,
  input  logic [W-1:0]   wr_data,
  input  logic           mode_tt,
  input  logic           tick,
  input  logic [W-1:0]   ref_cnt,
  input  logic [W-1:0]   cyc_cnt,
  output logic [N*W-1:0] cmp_flat,
  output logic [N-1:0]   match
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_cmp
      logic [W-1:0] cmp_q;
      logic [W-1:0] watched;

      always_ff @(posedge clk) begin
        if (rst)             cmp_q <= '0;
        else if (wr_sel[gi]) cmp_q <= wr_data;
      end

      if (gi == 0) begin : g_ref_only
        assign watched = ref_cnt;
      end else begin : g_mode_sel
        assign watched = mode_tt ? cyc_cnt : ref_cnt;
      end

      assign match[gi]             = tick && (watched == cmp_q);
      assign cmp_flat[gi*W +: W]   = cmp_q;
    end
  endgenerate
endmodule

// File: rtl/ttc_flag_irq.sv
module ttc_flag_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] match,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] irq_en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] clr_vec;
  logic [N-1:0] flags_nxt;

  always_comb begin
    clr_vec   = clr_we ? clr_mask : '0;
    flags_nxt = (flags & ~clr_vec) | match;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_nxt;
      irq   <= |(flags_nxt & irq_en);
    end
  end
endmodule

// File: rtl/ttc_timer_cmp.sv
module ttc_timer_cmp
  import ttc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               mode_tt,
  input  logic               clr_on_match,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [CNT_W-1:0]   rd_data,
  input  logic [NUM_CMP-1:0] irq_en,
  output logic [NUM_CMP-1:0] flags,
  output logic               irq
);
  logic [CNT_W-1:0]         ref_cnt;
  logic [CNT_W-1:0]         cyc_cnt;
  logic [NUM_CMP*CNT_W-1:0] cmp_flat;
  logic [NUM_CMP-1:0]       match;
  logic [NUM_CMP-1:0]       cmp_wr_sel;
  logic                     ref_load;
  logic                     cyc_load;
  logic                     flag_clr_we;
  logic                     ref_clear;
  logic [CNT_W-1:0]         rd_nxt;

  assign ref_load    = wr_en && (wr_addr == A_REF);
  assign cyc_load    = wr_en && (wr_addr == A_CYC);
  assign flag_clr_we = wr_en && (wr_addr == A_FLAG);
  assign ref_clear   = match[0] && !mode_tt && clr_on_match;

  always_comb begin
    for (int i = 0; i < NUM_CMP; i++)
      cmp_wr_sel[i] = wr_en && (wr_addr == cmp_addr(i));
  end

  ttc_counter #(.W(CNT_W), .CLEARABLE(1'b1)) u_ref (
    .clk(clk), .rst(rst), .tick(tick_en), .clear(ref_clear),
    .load(ref_load), .load_val(wr_data), .cnt(ref_cnt)
  );

  ttc_counter #(.W(CNT_W), .CLEARABLE(1'b0)) u_cyc (
    .clk(clk), .rst(rst), .tick(tick_en), .clear(1'b0),
    .load(cyc_load), .load_val(wr_data), .cnt(cyc_cnt)
  );

  ttc_cmp_bank #(.W(CNT_W), .N(NUM_CMP)) u_cmp (
    .clk(clk), .rst(rst), .wr_sel(cmp_wr_sel), .wr_data(wr_data),
    .mode_tt(mode_tt), .tick(tick_en), .ref_cnt(ref_cnt),
    .cyc_cnt(cyc_cnt), .cmp_flat(cmp_flat), .match(match)
  );

  ttc_flag_irq #(.N(NUM_CMP)) u_flag (
    .clk(clk), .rst(rst), .match(match), .clr_we(flag_clr_we),
    .clr_mask(wr_data[NUM_CMP-1:0]), .irq_en(irq_en),
    .flags(flags), .irq(irq)
  );

  always_comb begin
    rd_nxt = '0;
    if (rd_addr == A_REF)  rd_nxt = ref_cnt;
    if (rd_addr == A_CYC)  rd_nxt = cyc_cnt;
    if (rd_addr == A_FLAG) rd_nxt = CNT_W'(flags);
    for (int i = 0; i < NUM_CMP; i++)
      if (rd_addr == cmp_addr(i)) rd_nxt = cmp_flat[i*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end
endmodule

// File: rtl/ttc_timer_cmp_chk.sv
module ttc_timer_cmp_chk
  import ttc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_en,
  input logic               mode_tt,
  input logic               clr_on_match,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [NUM_CMP-1:0] irq_en,
  input logic [NUM_CMP-1:0] flags,
  input logic               irq,
  input logic [CNT_W-1:0]   ref_cnt,
  input logic [CNT_W-1:0]   cyc_cnt,
  input logic [CNT_W-1:0]   cmp0
);
  logic wr_ref, wr_cyc, wr_flag, hit0, et_clear;
  assign wr_ref   = wr_en && (wr_addr == A_REF);
  assign wr_cyc   = wr_en && (wr_addr == A_CYC);
  assign wr_flag  = wr_en && (wr_addr == A_FLAG);
  assign hit0     = tick_en && (ref_cnt == cmp0);
  assign et_clear = !mode_tt && clr_on_match && hit0;

  a_r2_ref_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !wr_ref) |=> $stable(ref_cnt));

  a_r2_cyc_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !wr_cyc) |=> $stable(cyc_cnt));

  a_r3_clear_on_cmp0: assert property (@(posedge clk) disable iff (rst)
    (et_clear && !wr_ref) |=> (ref_cnt == '0));

  a_r4_count_up: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !wr_ref && !et_clear) |=> (ref_cnt == CNT_W'($past(ref_cnt) + 1)));

  a_r7_flag0_set: assert property (@(posedge clk) disable iff (rst)
    hit0 |=> flags[0]);

  a_r8_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !wr_flag |=> ((flags & $past(flags)) == $past(flags)));

  a_r9_irq_combine: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == |(flags & $past(irq_en))));
endmodule

bind ttc_timer_cmp ttc_timer_cmp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .mode_tt(mode_tt),
  .clr_on_match(clr_on_match), .wr_en(wr_en), .wr_addr(wr_addr),
  .irq_en(irq_en), .flags(flags), .irq(irq), .ref_cnt(ref_cnt),
  .cyc_cnt(cyc_cnt), .cmp0(cmp_flat[CNT_W-1:0])
);

// File: tb/tb_ttc_timer_cmp.sv
module tb_ttc_timer_cmp;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en = 1'b0, mode_tt = 1'b0, clr_on_match = 1'b0, wr_en = 1'b0;
  logic [2:0]   wr_addr = '0, rd_addr = '0, irq_en = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [2:0]   flags;
  logic         irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int r_ref, r_cyc, r_flags, r_irq;
  int r_cmp [3];

  always #2 clk = ~clk;

  ttc_timer_cmp #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .mode_tt(mode_tt),
    .clr_on_match(clr_on_match), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_en(irq_en), .flags(flags), .irq(irq)
  );

  task automatic chk(input string lab, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", lab, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    case (a)
      0: return r_ref;
      1: return r_cyc;
      2, 3, 4: return r_cmp[a-2];
      5: return r_flags;
      default: return 0;
    endcase
  endfunction

  task automatic step(input bit t, input bit we, input int wa, input int wd, input int ra);
    int match, sel, n_ref, n_cyc, n_flags, exp_rd, clrm;
    bit hit;
    string lab;
    tick_en = t; wr_en = we; wr_addr = 3'(wa); wr_data = W'(wd); rd_addr = 3'(ra);
    match = 0;
    for (int k = 0; k < 3; k++) begin
      sel = (k != 0 && mode_tt) ? r_cyc : r_ref;
      if (t && sel == r_cmp[k]) match |= (1 << k);
    end
    hit    = match[0] && !mode_tt && clr_on_match;
    exp_rd = model_read(ra);
    n_ref  = (we && wa == 0) ? (wd & M) : (t ? (hit ? 0 : ((r_ref + 1) & M)) : r_ref);
    n_cyc  = (we && wa == 1) ? (wd & M) : (t ? ((r_cyc + 1) & M) : r_cyc);
    clrm   = (we && wa == 5) ? (wd & 7) : 0;
    n_flags = (r_flags & ~clrm & 7) | match;
    @(posedge clk);
    @(negedge clk);
    r_ref = n_ref; r_cyc = n_cyc; r_flags = n_flags;
    if (we && wa >= 2 && wa <= 4) r_cmp[wa-2] = wd & M;
    r_irq = ((r_flags & int'(irq_en)) != 0) ? 1 : 0;
    chk(mode_tt ? "R6 R7 flags" : "R5 R7 flags", int'(flags), r_flags);
    chk("R9 irq", int'(irq), r_irq);
    if (ra == 0)      lab = (!mode_tt && clr_on_match) ? "R3 ref read" : "R4 R2 ref read";
    else if (ra == 1) lab = "R2 cycle read";
    else if (ra == 5) lab = "R8 flag read";
    else              lab = "R10 read";
    chk(lab, int'(rd_data), exp_rd);
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    r_ref = 0; r_cyc = 0; r_flags = 0; r_irq = 0;
    for (int k = 0; k < 3; k++) r_cmp[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 flags after reset", int'(flags), 0);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 rd_data after reset", int'(rd_data), 0);
    for (int a = 0; a < 8; a++) step(1'b0, 1'b0, 0, 0, a);

    // Sweep: every mode, clear setting and compare-0 value (R2..R7, R9, R10)
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++)
        for (int v = 0; v <= M; v++) begin
          mode_tt = m[0]; clr_on_match = c[0]; irq_en = 3'(v + m);
          step(1'b0, 1'b1, 2, v, 2);
          step(1'b0, 1'b1, 3, (v + 5) & M, 3);
          step(1'b0, 1'b1, 4, (v * 3 + 1) & M, 4);
          step(1'b0, 1'b1, 0, (v + 11) & M, 0);
          step(1'b0, 1'b1, 1, (v + 2) & M, 1);
          step(1'b0, 1'b1, 5, 7, 5);
          for (int i = 0; i < 40; i++)
            step((i % 4) != 3, 1'b0, 0, 0, i % 6);
        end

    // R8: clear in the same cycle as a match leaves the flag set
    mode_tt = 1'b0; clr_on_match = 1'b0; irq_en = 3'b001;
    step(1'b0, 1'b1, 5, 7, 5);
    step(1'b0, 1'b1, 2, 5, 0);
    step(1'b0, 1'b1, 0, 5, 0);
    step(1'b1, 1'b1, 5, 1, 5);
    chk("R8 set wins over clear", int'(flags[0]), 1);
    chk("R9 irq with flag 0 enabled", int'(irq), 1);
    step(1'b0, 1'b1, 5, 0, 5);
    chk("R8 zero write keeps flag", int'(flags[0]), 1);
    step(1'b0, 1'b1, 5, 1, 5);
    chk("R8 one write clears flag", int'(flags[0]), 0);

    // R10: counter write wins over a tick
    step(1'b1, 1'b1, 0, 9, 0);
    step(1'b0, 1'b0, 0, 0, 0);
    chk("R10 write over tick", int'(rd_data), 9);

    // R2: wrap from all-ones
    step(1'b0, 1'b1, 1, M, 1);
    step(1'b1, 1'b0, 0, 0, 1);
    step(1'b0, 1'b0, 0, 0, 1);
    chk("R2 cycle wrap", int'(rd_data), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule